// File: doc/BRIEF.md
# Sized Shift and Rotate Unit with Condition Flags

This block shifts or rotates a 32-bit operand left or right by a 6-bit count. It works on the low byte, the low word or the whole long word. Three kinds of operation are offered. An arithmetic shift fills vacated bits with the sign of the selected size. A logical shift fills them with zeros. A rotate feeds the bits that leave one end back in at the other end. Bits above the selected size come through unchanged. Next to the result the block produces five condition flags: extend, negative, zero, overflow and carry.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream after one register stage. An input is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output holds its result and flags, and the block takes no new input. The current extend flag comes in on `in_xflag`, so that operations which do not change X can return it as it was.

Top module: `shrot_unit`

## Requirements
- R1: `in_size` picks the operand width: 0 = byte (8), 1 = word (16), 2 = long (32), 3 = word (the default size).
- R2: The arithmetic kind (`in_kind` = 0) fills vacated bits on a right shift with the sign bit of the selected size, and fills them with zeros on a left shift.
- R3: The logical kind (`in_kind` = 1, and also 3) fills vacated bits with zeros in both directions.
- R4: An arithmetic left shift sets V when the most significant bit of the selected size takes a different value at any step of the shift, counting the zeros that shift in. An arithmetic right shift always clears V.
- R5: For a nonzero count, C is the last bit shifted out. If the count is larger than the width, C is the fill value: zero for logical shifts and left shifts, the sign for an arithmetic right shift.
- R6: N is the most significant bit of the result at the selected size. Z is set exactly when the result bits within the selected size are all zero.
- R7: The rotate kind (`in_kind` = 2) rotates within the selected size by the count modulo the width. `in_left` = 1 selects left. For a nonzero count, C is the result's least significant bit after a left rotate and its most significant in-size bit after a right rotate. X is always returned as `in_xflag`.
- R8: The count ranges over 0 to 63. A count of zero leaves the result equal to the operand, clears C and V, and returns X as `in_xflag`.
- R9: For shifts with a nonzero count, X equals C.
- R10: Logical shifts and rotates always clear V.
- R11: Result bits above the selected size equal the corresponding operand bits.
- R12: `in_ready` = !`out_valid` || `out_ready`. A result appears on the cycle after its acceptance. While `out_valid` is high and `out_ready` is low, the result and flags stay stable. After reset `out_valid` is 0 and the flags are 0. `out_flags` is {X,N,Z,V,C} from bit 4 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_operand | input | 32 | Operand to shift or rotate |
| in_count | input | 6 | Shift or rotate count |
| in_kind | input | 2 | 0 arithmetic, 1 logical, 2 rotate, 3 logical |
| in_left | input | 1 | 1 = left, 0 = right |
| in_size | input | 2 | 0 byte, 1 word, 2 long, 3 word |
| in_xflag | input | 1 | Current extend flag |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Result, upper bits passed through |
| out_flags | output | 5 | {X,N,Z,V,C} |

## Verification
The bench aims at counts equal to, one above and far beyond the operand width. A design that wrapped the shift count, or that took the carry from the wrong end, would return stale bits or a wrong C in these cases. Arithmetic left shifts of values whose top bits differ only deep below the sign bit catch an overflow test that compares only the first and last sign. Rotates by exact multiples of the width catch a design that clears C, or that leaves X unpreserved, when the bit pattern does not move. Stalling the output with a second request waiting shows whether the design overwrites the held result or accepts the waiting request too early.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [1:0] {
    K_ARITH  = 2'd0,
    K_LOGIC  = 2'd1,
    K_ROTATE = 2'd2,
    K_LOGIC2 = 2'd3
  } shrot_kind_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_LONG  = 2'd2,
    SZ_WORD2 = 2'd3
  } shrot_size_e;

  localparam int FLAG_X = 4;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_V = 1;
  localparam int FLAG_C = 0;
endpackage

// File: rtl/shrot_lane.sv
module shrot_lane
  import shrot_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 6
) (
  input  logic [W-1:0]     val,
  input  logic [CNT_W-1:0] cnt,
  input  logic [1:0]       kind,
  input  logic             left,
  output logic [W-1:0]     res,
  output logic             carry,
  output logic             ovf
);
  localparam int RB = $clog2(W);
  localparam int XW = 2 * W + 2;

  int unsigned   sh;
  logic          fill;
  logic [XW-1:0] rvec, lvec;
  logic [2*W-1:0] dbl, rot_l, rot_r;
  logic [RB-1:0] rcnt;
  logic [W-1:0]  shift_res, rot_res;
  logic          shift_c, rot_c, msb_moves;

  always_comb begin
    sh   = (int'(cnt) > W + 1) ? (W + 1) : int'(cnt);
    fill = (kind == K_ARITH) && !left && val[W-1];
    rvec = {{(W + 1){fill}}, val, 1'b0} >> sh;
    lvec = {{(W + 2){1'b0}}, val} << sh;
    if (left) begin
      shift_res = lvec[W-1:0];
      shift_c   = lvec[W];
    end else begin
      shift_res = rvec[W:1];
      shift_c   = rvec[0];
    end
  end

  always_comb begin
    dbl   = {val, val};
    rcnt  = cnt[RB-1:0];
    rot_l = dbl << rcnt;
    rot_r = dbl >> rcnt;
    rot_res = left ? rot_l[2*W-1:W] : rot_r[W-1:0];
    rot_c   = (cnt == '0) ? 1'b0 : (left ? rot_res[0] : rot_res[W-1]);
  end

  always_comb begin
    msb_moves = (sh >= W) && val[W-1];
    for (int i = 0; i < W; i++) begin
      if ((i + int'(sh) >= W - 1) && (val[i] != val[W-1])) msb_moves = 1'b1;
    end
  end

  always_comb begin
    if (kind == K_ROTATE) begin
      res   = rot_res;
      carry = rot_c;
      ovf   = 1'b0;
    end else begin
      res   = shift_res;
      carry = shift_c;
      ovf   = (kind == K_ARITH) && left && msb_moves;
    end
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_operand,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [1:0]        in_kind,
  input  logic              in_left,
  input  logic [1:0]        in_size,
  input  logic              in_xflag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [4:0]        out_flags
);
  localparam int NLANE = 3;

  logic [DATA_W-1:0] lane_res  [NLANE];
  logic [DATA_W-1:0] lane_mask [NLANE];
  logic [NLANE-1:0]  lane_c, lane_v, lane_n, lane_z;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LW = DATA_W >> (NLANE - 1 - g);
    logic [LW-1:0] r;
    logic          c, v;
    shrot_lane #(.W(LW), .CNT_W(CNT_W)) i_lane (
      .val(in_operand[LW-1:0]), .cnt(in_count), .kind(in_kind),
      .left(in_left), .res(r), .carry(c), .ovf(v)
    );
    assign lane_res[g]  = DATA_W'(r);
    assign lane_mask[g] = DATA_W'({LW{1'b1}});
    assign lane_c[g]    = c;
    assign lane_v[g]    = v;
    assign lane_n[g]    = r[LW-1];
    assign lane_z[g]    = (r == '0);
  end

  int unsigned       sel;
  logic [DATA_W-1:0] nxt_result;
  logic [4:0]        nxt_flags;
  logic              nxt_x;
  logic              accept;

  always_comb begin
    unique case (shrot_size_e'(in_size))
      SZ_BYTE: sel = 0;
      SZ_LONG: sel = 2;
      default: sel = 1;
    endcase
    nxt_result = (in_operand & ~lane_mask[sel]) | lane_res[sel];
    if (in_kind == K_ROTATE || in_count == '0) nxt_x = in_xflag;
    else                                       nxt_x = lane_c[sel];
    nxt_flags = '0;
    nxt_flags[FLAG_X] = nxt_x;
    nxt_flags[FLAG_N] = lane_n[sel];
    nxt_flags[FLAG_Z] = lane_z[sel];
    nxt_flags[FLAG_V] = lane_v[sel];
    nxt_flags[FLAG_C] = lane_c[sel];
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_flags  <= '0;
    end else begin
      if (accept) begin
        out_valid  <= 1'b1;
        out_result <= nxt_result;
        out_flags  <= nxt_flags;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R12: a held result stays put under back-pressure
  a_r12_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_flags)));

  // R12: an accepted request shows up on the next cycle
  a_r12_latency: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R10: logical shifts and rotates never raise V
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_kind != K_ARITH) |=> !out_flags[FLAG_V]);

  // R8: zero count keeps the operand and the extend flag, clears carry
  a_r8_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_count == '0) |=> (out_result == $past(in_operand) &&
      !out_flags[FLAG_C] && out_flags[FLAG_X] == $past(in_xflag)));

  // R7: rotates keep the extend flag
  a_r7_rot_keeps_x: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_kind == K_ROTATE) |=> out_flags[FLAG_X] == $past(in_xflag));

  // R11: bits above a byte operand pass through
  a_r11_byte_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_size == SZ_BYTE) |=> out_result[DATA_W-1:8] == $past(in_operand[DATA_W-1:8]));

  // R4: arithmetic right shift never raises V
  a_r4_asr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_kind == K_ARITH && !in_left) |=> !out_flags[FLAG_V]);
endmodule

// File: tb/test_shrot_unit.sv
`timescale 1ns/1ps
module test_shrot_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_operand = '0;
  logic [5:0]  in_count = '0;
  logic [1:0]  in_kind = '0;
  logic        in_left = 1'b0;
  logic [1:0]  in_size = '0;
  logic        in_xflag = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic [4:0]  out_flags;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  shrot_unit i_shrot_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_count(in_count), .in_kind(in_kind),
    .in_left(in_left), .in_size(in_size), .in_xflag(in_xflag),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_flags(out_flags)
  );

  // Step-by-step reference: returns {flags[4:0], result[31:0]}
  function automatic logic [36:0] ref_op(input logic [31:0] op, input int cnt,
      input logic [1:0] kind, input logic left, input logic [1:0] size, input logic xin);
    int w;
    logic [31:0] mask, v;
    logic c, x, vf, m;
    w = (size == 2'd0) ? 8 : (size == 2'd2) ? 32 : 16;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    v = op & mask; c = 1'b0; x = xin; vf = 1'b0;
    for (int i = 0; i < cnt; i++) begin
      m = v[w-1];
      if (kind == 2'd2) begin
        if (left) begin c = m; v = ((v << 1) | {31'd0, c}) & mask; end
        else begin c = v[0]; v = (v >> 1) | ({31'd0, c} << (w - 1)); end
      end else if (left) begin
        c = m; v = (v << 1) & mask;
        if (kind == 2'd0 && v[w-1] != m) vf = 1'b1;
      end else begin
        c = v[0]; v = v >> 1;
        if (kind == 2'd0 && m) v = v | (32'd1 << (w - 1));
      end
    end
    if (kind != 2'd2 && cnt != 0) x = c;
    ref_op = {x, v[w-1], (v == 0), vf, c, (op & ~mask) | v};
  endfunction

  task automatic check(input string tag, input logic [36:0] act, input logic [36:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got flags=%b result=%h, expected flags=%b result=%h",
               tag, act[36:32], act[31:0], exp[36:32], exp[31:0]);
    end
  endtask

  task automatic run_op(input string tag, input logic [31:0] op, input int cnt,
      input logic [1:0] kind, input logic left, input logic [1:0] size, input logic xin);
    @(negedge clk);
    in_operand = op; in_count = 6'(cnt); in_kind = kind;
    in_left = left; in_size = size; in_xflag = xin; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, {out_flags, out_result}, ref_op(op, cnt, kind, left, size, xin));
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [36:0] exp_a, exp_b;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R12 reset state
    checks++;
    if (out_valid !== 1'b0 || out_flags !== 5'd0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R12 reset: got v=%b f=%b r=%b, expected v=0 f=0 r=1", out_valid, out_flags, in_ready);
    end
    rst_n = 1'b1;

    // Directed corners
    run_op("R4 asl byte sign change", 32'h0000_0040, 1, 2'd0, 1'b1, 2'd0, 1'b0);
    run_op("R4 asl deep change",      32'h0000_3FFF, 2, 2'd0, 1'b1, 2'd1, 1'b0);
    run_op("R4 asl no change",        32'h0000_F000, 3, 2'd0, 1'b1, 2'd1, 1'b0);
    run_op("R4 asr clears V",         32'h0000_8001, 5, 2'd0, 1'b0, 2'd1, 1'b1);
    run_op("R2 asr sign fill byte",   32'hABCD_EF90, 3, 2'd0, 1'b0, 2'd0, 1'b0);
    run_op("R5 asr beyond width",     32'h0000_8000, 40, 2'd0, 1'b0, 2'd1, 1'b0);
    run_op("R5 lsl count eq width",   32'h0000_0001, 16, 2'd1, 1'b1, 2'd1, 1'b0);
    run_op("R5 lsr count width+1",    32'hFFFF_FFFF, 33, 2'd1, 1'b0, 2'd2, 1'b1);
    run_op("R3 lsr zero fill long",   32'h8000_0000, 31, 2'd1, 1'b0, 2'd2, 1'b0);
    run_op("R3 kind 3 is logical",    32'h0000_0080, 1, 2'd3, 1'b0, 2'd0, 1'b0);
    run_op("R8 zero count",           32'h1234_5678, 0, 2'd0, 1'b1, 2'd2, 1'b1);
    run_op("R7 rotate by width",      32'h0000_8001, 16, 2'd2, 1'b1, 2'd1, 1'b0);
    run_op("R7 rotate right byte",    32'h5555_5501, 1, 2'd2, 1'b0, 2'd0, 1'b1);
    run_op("R1 size 3 acts as word",  32'hFFFF_8000, 1, 2'd1, 1'b1, 2'd3, 1'b0);
    run_op("R6 zero result flag",     32'h0000_0100, 1, 2'd1, 1'b1, 2'd0, 1'b0);
    run_op("R9 X follows C",          32'h0000_0001, 1, 2'd1, 1'b0, 2'd2, 1'b0);
    run_op("R11 upper pass word",     32'hDEAD_0F0F, 4, 2'd2, 1'b1, 2'd1, 1'b0);

    // R12 back-pressure
    exp_a = ref_op(32'h0000_00F0, 2, 2'd1, 1'b1, 2'd0, 1'b0);
    exp_b = ref_op(32'h0000_1234, 4, 2'd2, 1'b0, 2'd1, 1'b0);
    @(negedge clk);
    out_ready = 1'b0;
    in_operand = 32'h0000_00F0; in_count = 6'd2; in_kind = 2'd1; in_left = 1'b1;
    in_size = 2'd0; in_xflag = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_operand = 32'h0000_1234; in_count = 6'd4; in_kind = 2'd2; in_left = 1'b0; in_size = 2'd1;
    checks++;
    if (in_ready !== 1'b0) begin
      errors++; $display("FAIL R12 stall ready: got %b, expected 0", in_ready);
    end
    repeat (2) @(negedge clk);
    check("R12 held result", {out_flags, out_result}, exp_a);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R12 next after stall", {out_flags, out_result}, exp_b);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [1:0] k;
      logic [31:0] op;
      int cnt;
      k = 2'($urandom_range(0, 3));
      op = $urandom();
      cnt = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 63) : $urandom_range(0, 17);
      run_op(k == 2'd0 ? "R2 random arith" : (k == 2'd2 ? "R7 random rotate" : "R3 random logical"),
             op, cnt, k, 1'($urandom()), 2'($urandom()), 1'($urandom()));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule